// File: doc/BRIEF.md
# Status-Register Flash Program/Erase Sequencer

This block turns a single host request into the full command exchange needed by a parallel NOR flash that reports progress through a status register. A word-program request carries an address and a data word. A block-erase request carries a block address. The sequencer issues the command writes on a request/ready flash bus and polls the status word until every lane reports ready or a cycle-count timeout expires. It then checks the error flag, puts the device back into array-read mode and returns a two-bit result code.

Each command byte is placed in the low byte of every 16-bit lane of the bus word, with the high byte zero, so one command reaches all devices sharing the bus. A program is refused before any write when the target word already holds a zero where the new data has a one. Both kinds of request share one timer: it measures the minimum erase wait and then the poll timeout.

Top module: `flash_cmd_seq`

## Requirements
- R1: A program request (host_op=0) first reads the target word. If (current AND new) differs from new, the block returns code 2 and performs no bus write.
- R2: An accepted program writes, all to the target address, clear-status 0x50, read-mode 0xFF, program-setup 0x40, then the data word. Every command word is 0x00CC in each 16-bit lane (0x00CC00CC on a 32-bit bus).
- R3: An erase request (host_op=1) writes 0x50, 0x20 and 0xD0 to the block address. When it completes it writes read-mode 0xFF.
- R4: After the erase confirm write is accepted, the first status read is accepted exactly ERASE_WAIT+1 cycles later when the bus never stalls.
- R5: A status word counts as ready only when bit 7 of every 16-bit lane is set. A word with bit 7 set in lane 0 only keeps polling.
- R6: Poll k (k=0,1,...) observes k cycles since the last command write (k cycles since the end of the wait for an erase). A not-ready poll with k at or above the timeout (PROG_TOUT or ERASE_TOUT) writes suspend 0xB0 and gives code 1. A ready poll with k equal to the timeout still succeeds.
- R7: A program that completes within the timeout but has bit 4 set in any lane gives code 1 and writes no suspend.
- R8: Every program that passed the erased check ends with 0x50 then 0xFF, after the suspend if one was written. Every erase ends with 0xFF only.
- R9: Code 0 means success. host_done is a one-cycle pulse carrying host_code. host_busy is high from the cycle after acceptance until the done pulse, and the flash bus is idle while host_busy is low.
- R10: host_req is ignored while host_busy is high. No second sequence is started.
- R11: While fl_req is high and fl_ready is low, fl_we, fl_addr and fl_wdata hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| host_req | input | 1 | Request strobe, accepted when idle |
| host_op | input | 1 | 0 = word program, 1 = block erase |
| host_addr | input | ADDR_W | Target word or block address |
| host_data | input | DATA_W | Program data |
| host_busy | output | 1 | Sequence in progress |
| host_done | output | 1 | One-cycle completion pulse |
| host_code | output | 2 | 0 ok, 1 timeout or device error, 2 not erased |
| fl_req | output | 1 | Flash access request |
| fl_we | output | 1 | 1 = write, 0 = read |
| fl_addr | output | ADDR_W | Flash word address |
| fl_wdata | output | DATA_W | Flash write data |
| fl_ready | input | 1 | Access accepted this cycle |
| fl_rdata | input | DATA_W | Read data, valid when fl_ready |

## Verification
The delicate case is a poll that returns ready in the same cycle the timer reaches its limit; ready must win over suspend. The bench sweeps how many not-ready status words the flash model returns, from zero to two past each timeout, for both program and erase. It computes from the poll index whether the sweep point lands just inside or just past the limit, then compares the logged write sequence and the code with that expectation.

// File: rtl/fseq_pkg.sv
// Shared types and command values for the flash command sequencer.
// Assumes status-register style devices, 16-bit lanes, command in low byte.
package fseq_pkg;

    typedef enum logic [3:0] {
        S_IDLE, S_CHK, S_CLR, S_RDM, S_PSET, S_PDATA, S_ESET, S_ECONF,
        S_WAIT, S_POLL, S_SUSP, S_FCLR, S_FRDM
    } seq_state_t;

    localparam logic [7:0] CMD_CLR_STAT = 8'h50;
    localparam logic [7:0] CMD_RD_ARRAY = 8'hFF;
    localparam logic [7:0] CMD_PROG_SET = 8'h40;
    localparam logic [7:0] CMD_ERAS_SET = 8'h20;
    localparam logic [7:0] CMD_ERAS_GO  = 8'hD0;
    localparam logic [7:0] CMD_SUSPEND  = 8'hB0;

    localparam logic [1:0] RES_OK         = 2'd0;
    localparam logic [1:0] RES_FAIL       = 2'd1;
    localparam logic [1:0] RES_NOT_ERASED = 2'd2;

endpackage

// File: rtl/fseq_timer.sv
// Saturating cycle counter shared by erase wait and poll timeout.
// Assumes clr has priority; the count stops at all ones.
module fseq_timer #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    output logic [W-1:0] cnt
);
    // count cycles since the last clear, saturating
    always_ff @(posedge clk) begin
        if (!rst_n)          cnt <= '0;
        else if (clr)        cnt <= '0;
        else if (cnt != '1)  cnt <= cnt + 1'b1;
    end

    assert_sat_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt == '1 && !clr) |=> (cnt == '1));
    assert_clear_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (cnt == '0));
endmodule

// File: rtl/fseq_resp_eval.sv
// Decodes a flash read word: all-lane ready (bit 7), any-lane error (bit 4),
// and whether the word covers the wanted ones (erased check).
// Assumes DATA_W is a multiple of 16.
module fseq_resp_eval #(
    parameter int DATA_W = 32
) (
    input  logic [DATA_W-1:0] word,
    input  logic [DATA_W-1:0] want,
    output logic              all_ready,
    output logic              any_err,
    output logic              covers
);
    localparam int LANES = DATA_W / 16;

    logic [LANES-1:0] rdy_l;
    logic [LANES-1:0] err_l;

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        assign rdy_l[g] = word[16*g + 7];
        assign err_l[g] = word[16*g + 4];
    end

    // reduce per-lane flags and compare against the wanted pattern
    always_comb begin
        all_ready = &rdy_l;
        any_err   = |err_l;
        covers    = ((word & want) == want);
    end
endmodule

// File: rtl/flash_cmd_seq.sv
// Program/erase command sequencer for status-register parallel NOR flash.
// Accepts one host request at a time, drives command writes on a
// request/ready bus, polls status with a timeout, suspends on timeout,
// restores read mode and reports a result code.
// Assumes fl_rdata is valid in the cycle fl_req && fl_ready.
module flash_cmd_seq
    import fseq_pkg::*;
#(
    parameter int ADDR_W     = 16,
    parameter int DATA_W     = 32,
    parameter int PROG_TOUT  = 2000,
    parameter int ERASE_TOUT = 100000,
    parameter int ERASE_WAIT = 1000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              host_req,
    input  logic              host_op,
    input  logic [ADDR_W-1:0] host_addr,
    input  logic [DATA_W-1:0] host_data,
    output logic              host_busy,
    output logic              host_done,
    output logic [1:0]        host_code,
    output logic              fl_req,
    output logic              fl_we,
    output logic [ADDR_W-1:0] fl_addr,
    output logic [DATA_W-1:0] fl_wdata,
    input  logic              fl_ready,
    input  logic [DATA_W-1:0] fl_rdata
);
    localparam int LANES  = DATA_W / 16;
    localparam int MAXA   = (PROG_TOUT > ERASE_TOUT) ? PROG_TOUT : ERASE_TOUT;
    localparam int MAXC   = (MAXA > ERASE_WAIT) ? MAXA : ERASE_WAIT;
    localparam int TW     = $clog2(MAXC + 2);

    seq_state_t        state;
    logic              op_q;
    logic [ADDR_W-1:0] addr_q;
    logic [DATA_W-1:0] data_q;
    logic [1:0]        code_q;
    logic [7:0]        cmd_byte;
    logic [DATA_W-1:0] cmd_word;
    logic              ack, all_rdy, any_err, covers;
    logic              wait_over, tmr_clr;
    logic [TW-1:0]     tmr_cnt, limit;

    fseq_timer #(.W(TW)) u_timer (
        .clk(clk), .rst_n(rst_n), .clr(tmr_clr), .cnt(tmr_cnt)
    );

    fseq_resp_eval #(.DATA_W(DATA_W)) u_eval (
        .word(fl_rdata), .want(data_q),
        .all_ready(all_rdy), .any_err(any_err), .covers(covers)
    );

    // replicate the command byte into each 16-bit lane
    for (genvar g = 0; g < LANES; g++) begin : g_rep
        assign cmd_word[16*g +: 16] = {8'h00, cmd_byte};
    end

    // bus drive and command selection from the current state
    always_comb begin
        cmd_byte = CMD_RD_ARRAY;
        fl_req   = 1'b1;
        fl_we    = 1'b1;
        unique case (state)
            S_CLR, S_FCLR: cmd_byte = CMD_CLR_STAT;
            S_PSET:        cmd_byte = CMD_PROG_SET;
            S_ESET:        cmd_byte = CMD_ERAS_SET;
            S_ECONF:       cmd_byte = CMD_ERAS_GO;
            S_SUSP:        cmd_byte = CMD_SUSPEND;
            S_CHK, S_POLL: fl_we    = 1'b0;
            S_IDLE, S_WAIT: begin fl_req = 1'b0; fl_we = 1'b0; end
            default:       cmd_byte = CMD_RD_ARRAY;
        endcase
        fl_addr   = addr_q;
        fl_wdata  = !fl_we ? '0 : (state == S_PDATA) ? data_q : cmd_word;
        ack       = fl_req && fl_ready;
        host_busy = (state != S_IDLE);
        limit     = op_q ? TW'(ERASE_TOUT) : TW'(PROG_TOUT);
        wait_over = (state == S_WAIT) && (tmr_cnt >= TW'(ERASE_WAIT - 1));
        tmr_clr   = wait_over || (ack && (state == S_PDATA || state == S_ECONF));
    end

    // sequence state, request capture and result reporting
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state     <= S_IDLE;
            op_q      <= 1'b0;
            addr_q    <= '0;
            data_q    <= '0;
            code_q    <= RES_OK;
            host_done <= 1'b0;
            host_code <= RES_OK;
        end else begin
            host_done <= 1'b0;
            unique case (state)
                S_IDLE: if (host_req) begin
                    op_q   <= host_op;
                    addr_q <= host_addr;
                    data_q <= host_data;
                    state  <= host_op ? S_CLR : S_CHK;
                end
                S_CHK: if (ack) begin
                    if (!covers) begin
                        host_code <= RES_NOT_ERASED;
                        host_done <= 1'b1;
                        state     <= S_IDLE;
                    end else begin
                        state <= S_CLR;
                    end
                end
                S_CLR:   if (ack) state <= op_q ? S_ESET : S_RDM;
                S_RDM:   if (ack) state <= S_PSET;
                S_PSET:  if (ack) state <= S_PDATA;
                S_PDATA: if (ack) state <= S_POLL;
                S_ESET:  if (ack) state <= S_ECONF;
                S_ECONF: if (ack) state <= S_WAIT;
                S_WAIT:  if (wait_over) state <= S_POLL;
                S_POLL: if (ack) begin
                    if (all_rdy) begin
                        code_q <= (!op_q && any_err) ? RES_FAIL : RES_OK;
                        state  <= op_q ? S_FRDM : S_FCLR;
                    end else if (tmr_cnt >= limit) begin
                        code_q <= RES_FAIL;
                        state  <= S_SUSP;
                    end
                end
                S_SUSP:  if (ack) state <= op_q ? S_FRDM : S_FCLR;
                S_FCLR:  if (ack) state <= S_FRDM;
                S_FRDM: if (ack) begin
                    host_code <= code_q;
                    host_done <= 1'b1;
                    state     <= S_IDLE;
                end
                default: state <= S_IDLE;
            endcase
        end
    end

    assert_bus_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (fl_req && !fl_ready) |=> (fl_req && $stable(fl_we) && $stable(fl_addr)
                                   && $stable(fl_wdata)));
    assert_done_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
        host_done |=> !host_done);
    assert_code_legal_R9: assert property (@(posedge clk) disable iff (!rst_n)
        host_done |-> (host_code != 2'd3));
    assert_idle_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !host_busy |-> !fl_req);
    assert_start_cause_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(host_busy) |-> $past(host_req));
    assert_reject_nowrite_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (host_done && host_code == RES_NOT_ERASED) |-> $past(fl_req && !fl_we));
endmodule

// File: tb/flash_cmd_seq_tb_top.sv
module flash_cmd_seq_tb_top;
    localparam int AW = 4, DW = 32, PT = 6, ET = 10, EW = 5;

    logic clk = 1'b0, rst_n = 1'b0;
    logic host_req = 1'b0, host_op = 1'b0;
    logic [AW-1:0] host_addr = '0;
    logic [DW-1:0] host_data = '0;
    logic host_busy, host_done, fl_req, fl_we, fl_ready;
    logic [1:0] host_code;
    logic [AW-1:0] fl_addr;
    logic [DW-1:0] fl_wdata, fl_rdata;

    always #4 clk = ~clk;

    flash_cmd_seq #(.ADDR_W(AW), .DATA_W(DW), .PROG_TOUT(PT),
                    .ERASE_TOUT(ET), .ERASE_WAIT(EW)) dut_i (
        .clk(clk), .rst_n(rst_n), .host_req(host_req), .host_op(host_op),
        .host_addr(host_addr), .host_data(host_data), .host_busy(host_busy),
        .host_done(host_done), .host_code(host_code), .fl_req(fl_req),
        .fl_we(fl_we), .fl_addr(fl_addr), .fl_wdata(fl_wdata),
        .fl_ready(fl_ready), .fl_rdata(fl_rdata));

    // flash model configuration (driven only by the stimulus block)
    int cfg_busy = 0;
    logic cfg_err = 1'b0, cfg_stall = 1'b0;
    // flash model state (driven only by the model)
    logic [DW-1:0] mem [16];
    logic [DW-1:0] wlog_d [512];
    logic [AW-1:0] wlog_a [512];
    int wcount = 0, rcount = 0, cyc = 0, conf_cyc = 0, first_poll = 0;
    int mode = 0, pend = 0, busy_left = 0;
    logic armed = 1'b0;

    int tests = 0, fails = 0;

    always @(posedge clk) cyc <= cyc + 1;

    assign fl_ready = cfg_stall ? (cyc % 2 == 0) : 1'b1;
    assign fl_rdata = (mode == 1) ?
        ((busy_left > 0) ? 32'h0000_0080
                         : (32'h0080_0080 | (cfg_err ? 32'h0010_0010 : 32'h0)))
        : mem[fl_addr];

    always @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < 16; i++) mem[i] <= 32'hFFFF_FFFF;
            mode <= 0; pend <= 0; busy_left <= 0; armed <= 1'b0;
        end else if (fl_req && fl_ready) begin
            if (fl_we) begin
                wlog_d[wcount] <= fl_wdata;
                wlog_a[wcount] <= fl_addr;
                wcount <= wcount + 1;
                if (pend == 1) begin
                    mem[fl_addr] <= mem[fl_addr] & fl_wdata;
                    pend <= 0; mode <= 1; busy_left <= cfg_busy;
                end else if (pend == 2 && fl_wdata[7:0] == 8'hD0) begin
                    for (int i = 0; i < 4; i++) mem[{fl_addr[3:2], 2'(i)}] <= 32'hFFFF_FFFF;
                    pend <= 0; mode <= 1; busy_left <= cfg_busy;
                    conf_cyc <= cyc; armed <= 1'b1;
                end else begin
                    case (fl_wdata[7:0])
                        8'hFF: begin mode <= 0; pend <= 0; end
                        8'h40: begin mode <= 1; pend <= 1; end
                        8'h20: begin mode <= 1; pend <= 2; end
                        default: mode <= 1;
                    endcase
                end
            end else begin
                rcount <= rcount + 1;
                if (mode == 1 && busy_left > 0) busy_left <= busy_left - 1;
                if (armed) begin first_poll <= cyc; armed <= 1'b0; end
            end
        end
    end

    function automatic logic [31:0] rep(int b);
        return {8'h00, 8'(b), 8'h00, 8'(b)};
    endfunction

    task automatic check(string req, logic ok, logic [31:0] act, logic [31:0] exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // compare logged writes from base against up to 7 entries (-1 = data word)
    task automatic chk_seq(string req, int base, int n, int e0, int e1, int e2,
                           int e3, int e4, int e5, int e6,
                           logic [31:0] pd, logic [AW-1:0] a);
        int e [7];
        logic ok;
        logic [31:0] bad_a, bad_e;
        e = '{e0, e1, e2, e3, e4, e5, e6};
        ok = (wcount - base == n);
        bad_a = 32'(wcount - base); bad_e = 32'(n);
        for (int i = 0; i < n && ok; i++) begin
            logic [31:0] x;
            x = (e[i] < 0) ? pd : rep(e[i]);
            if (wlog_d[base+i] !== x || wlog_a[base+i] !== a) begin
                ok = 1'b0; bad_a = wlog_d[base+i]; bad_e = x;
            end
        end
        check(req, ok, bad_a, bad_e);
    endtask

    task automatic run_op(input logic op, input logic [AW-1:0] a,
                          input logic [DW-1:0] d, input logic intrude,
                          output logic [1:0] code);
        int n;
        @(negedge clk);
        host_req = 1'b1; host_op = op; host_addr = a; host_data = d;
        @(negedge clk);
        host_req = 1'b0;
        check("R9 busy after accept", host_busy === 1'b1, 32'(host_busy), 32'h1);
        n = 0;
        while (host_done !== 1'b1 && n < 3000) begin
            if (intrude && n == 2) begin
                host_req = 1'b1; host_op = 1'b0; host_addr = '0; host_data = '0;
            end else host_req = 1'b0;
            @(negedge clk);
            n++;
        end
        host_req = 1'b0;
        check("R9 done seen", n < 3000, 32'(n), 32'd3000);
        code = host_code;
        check("R9 busy low at done", host_busy === 1'b0, 32'(host_busy), 32'h0);
        @(negedge clk);
        check("R9 done one cycle", host_done === 1'b0, 32'(host_done), 32'h0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("  [TB] %0d tests run, %0d failed", tests + 1, fails + 1);
        $finish;
    end

    initial begin
        logic [1:0] code;
        logic [31:0] d;
        int base, rb;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R9 reset busy", host_busy === 1'b0, 32'(host_busy), 0);
        check("R9 reset done", host_done === 1'b0, 32'(host_done), 0);
        check("R9 reset bus idle", fl_req === 1'b0, 32'(fl_req), 0);

        // R2 R8 plain program success
        base = wcount;
        run_op(1'b0, 4'd3, 32'h1234_5678, 1'b0, code);
        check("R9 program code ok", code == 2'd0, 32'(code), 0);
        chk_seq("R2 R8 program sequence", base, 6, 'h50, 'hFF, 'h40, -1, 'h50, 'hFF, 0,
                32'h1234_5678, 4'd3);
        check("R2 program stored", mem[3] == 32'h1234_5678, mem[3], 32'h1234_5678);

        // R1 not-erased reject
        base = wcount; rb = rcount;
        run_op(1'b0, 4'd3, 32'h00FF_0000, 1'b0, code);
        check("R1 reject code", code == 2'd2, 32'(code), 2);
        check("R1 no writes", wcount == base, 32'(wcount - base), 0);
        check("R1 one read", rcount - rb == 1, 32'(rcount - rb), 1);
        // R1 subset of current word is accepted
        base = wcount;
        run_op(1'b0, 4'd3, 32'h1024_0060, 1'b0, code);
        check("R1 subset accepted", code == 2'd0 && wcount - base == 6, 32'(code), 0);

        // R5 R6 program poll sweep across the timeout (partial-lane busy word)
        for (int r = 0; r <= PT + 2; r++) begin
            cfg_busy = r;
            d = ~((32'h2 << r) - 32'h1);
            base = wcount;
            run_op(1'b0, 4'd9, d, 1'b0, code);
            if (r <= PT) begin
                check("R5 R6 program ready within limit", code == 2'd0, 32'(code), 0);
                chk_seq("R6 program no suspend", base, 6, 'h50, 'hFF, 'h40, -1, 'h50, 'hFF, 0, d, 4'd9);
            end else begin
                check("R6 program timeout code", code == 2'd1, 32'(code), 1);
                chk_seq("R6 R8 program suspend then restore", base, 7, 'h50, 'hFF, 'h40, -1,
                        'hB0, 'h50, 'hFF, d, 4'd9);
            end
        end

        // R7 error bit after completion
        cfg_busy = 1; cfg_err = 1'b1;
        base = wcount;
        run_op(1'b0, 4'd10, 32'h0F0F_0F0F, 1'b0, code);
        check("R7 error code", code == 2'd1, 32'(code), 1);
        chk_seq("R7 R8 error no suspend", base, 6, 'h50, 'hFF, 'h40, -1, 'h50, 'hFF, 0,
                32'h0F0F_0F0F, 4'd10);
        cfg_err = 1'b0;

        // R3 R4 erase with minimum wait
        cfg_busy = 2;
        base = wcount;
        run_op(1'b1, 4'd6, 32'h0, 1'b0, code);
        check("R3 erase code", code == 2'd0, 32'(code), 0);
        chk_seq("R3 erase sequence", base, 4, 'h50, 'h20, 'hD0, 'hFF, 0, 0, 0, 0, 4'd6);
        check("R4 wait before first poll", first_poll - conf_cyc == EW + 1,
              32'(first_poll - conf_cyc), 32'(EW + 1));
        check("R3 block erased", mem[4] == '1 && mem[7] == '1 && mem[3] != '1, mem[4], 32'hFFFF_FFFF);

        // R6 erase poll sweep across the timeout
        for (int r = 0; r <= ET + 2; r++) begin
            cfg_busy = r;
            base = wcount;
            run_op(1'b1, 4'd1, 32'h0, 1'b0, code);
            if (r <= ET) begin
                check("R6 erase within limit", code == 2'd0, 32'(code), 0);
                chk_seq("R3 erase no suspend", base, 4, 'h50, 'h20, 'hD0, 'hFF, 0, 0, 0, 0, 4'd1);
            end else begin
                check("R6 erase timeout code", code == 2'd1, 32'(code), 1);
                chk_seq("R6 R8 erase suspend then read", base, 5, 'h50, 'h20, 'hD0, 'hB0,
                        'hFF, 0, 0, 0, 4'd1);
            end
        end

        // R11 stalled bus program
        cfg_busy = 3; cfg_stall = 1'b1;
        base = wcount;
        run_op(1'b0, 4'd11, 32'hA5A5_A5A5, 1'b0, code);
        check("R11 stalled program code", code == 2'd0, 32'(code), 0);
        chk_seq("R11 stalled sequence", base, 6, 'h50, 'hFF, 'h40, -1, 'h50, 'hFF, 0,
                32'hA5A5_A5A5, 4'd11);
        cfg_stall = 1'b0;

        // R10 request while busy is ignored
        cfg_busy = 2;
        base = wcount;
        run_op(1'b1, 4'd12, 32'h0, 1'b1, code);
        repeat (20) @(negedge clk);
        check("R10 busy request ignored", host_busy === 1'b0 && wcount - base == 4,
              32'(wcount - base), 4);
        chk_seq("R10 only first sequence", base, 4, 'h50, 'h20, 'hD0, 'hFF, 0, 0, 0, 0, 4'd12);

        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule